// File: doc/BRIEF.md
# Multi-Source Glitch-Free Clock Switch

This block selects one of `N` mutually asynchronous source clocks and drives one output clock from it. When the selection changes, the output keeps every pulse whole. No pulse is cut short and no narrow spike is produced. The output goes low after a complete high phase of the old source. It stays low until the new source has been enabled, and the first pulse from the new source is a complete one.

Each source has its own small path. First, a flop clocked on the rising edge of that source's clock samples a request. A second flop, clocked on the falling edge of the same clock, turns that request into the path enable. The request for a source is true only when both of these hold:
- the select index names that source;
- every other path is idle, meaning both its request flop and its enable flop are clear.

This interlock enforces break-before-make between any number of unrelated clocks. A one-hot status vector mirrors the enable flops, so the surrounding logic can see which source is currently passed through. The select and status pins are plain control and status signals with no handshake.

Top module: `clksw_top`

## Requirements
- R1: While a path's enable is set, the output clock equals that source clock. The output is the OR over all paths of each source ANDed with its enable.
- R2: At most one bit of `en_o` is set at any time. Bit i means source i is currently enabled.
- R3: After the select changes to source j, the old source's enable clears first. Only later does enable j set, and `en_o` settles to the one-hot code for j.
- R4: Outside reset, no high or low phase of `clk_o` is shorter than the shortest half-period among the running sources.
- R5: While `rst_ni` is low, every request and enable flop is clear, `en_o` is 0 and `clk_o` is low.
- R6: A select value of `N` or more enables no source. Once the current source has been turned off, `clk_o` stays low and `en_o` is 0.
- R7: A source whose clock never toggles does not prevent a working source from being selected afterwards. While such a source is selected, `en_o` stays 0 and `clk_o` stays low.
- R8: Each bit of `en_o` changes, outside reset, only while its own source clock is low.
- R9: From an idle state (all enables clear), selecting source j sets its enable at the first falling edge of clock j that follows a rising edge of clock j sampling the new select. The enable is still clear after that rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src_i | input | N | Source clocks, bit i is source i |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | SW | Binary index of the wanted source; values of N or more select none |
| clk_o | output | 1 | Gated output clock |
| en_o | output | N | One-hot view of the path enables |

## Verification
The bench builds the block with N = 3, so the select is two bits wide. This leaves index 3 free as an out-of-range code for the no-source case. The three sources run at unrelated periods of 7.0, 11.4 and 17.8 ns, and the third source can be held still. This makes it possible to reach the stuck-source case, to trigger handovers at arbitrary phase offsets, and to issue rapid select changes that arrive in the middle of a handover.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;

  // Width of the binary select index for n sources.
  function automatic int sel_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/clksw_path.sv
`timescale 1ns/1ps
// One source path: a rising-edge request flop, then a falling-edge enable flop.
module clksw_path #(
  parameter int N   = 3,
  parameter int IDX = 0,
  parameter int SW  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  input  logic          peer_busy_i,
  output logic          busy_o,
  output logic          en_o
);

  localparam logic [SW-1:0] CODE = SW'(IDX);

  logic req;
  logic sync_q;
  logic en_q;

  // Request only when this source is named and every other path is idle.
  assign req = (sel_i == CODE) && !peer_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= req;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= sync_q;
  end

  assign busy_o = sync_q | en_q;
  assign en_o   = en_q;

  // R5
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!sync_q && !en_q));

  // R9
  en_after_sync_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(sync_q));

  generate
    if ((1 << SW) > N) begin : g_range
      // R6
      out_of_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel_i) >= N) |=> !sync_q);
    end
  endgenerate

endmodule

// File: rtl/clksw_peers.sv
`timescale 1ns/1ps
// For each path, reduces the busy state of all other paths to one bit.
module clksw_peers #(
  parameter int N = 3
) (
  input  logic [N-1:0] busy_i,
  output logic [N-1:0] peer_busy_o
);

  for (genvar g = 0; g < N; g++) begin : g_peer
    localparam logic [N-1:0] SELF = N'(1) << g;
    assign peer_busy_o[g] = |(busy_i & ~SELF);
  end

endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
// AND-OR clock gate driven only by the enable flops.
module clksw_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] clk_src_i,
  input  logic [N-1:0] en_i,
  output logic         clk_o
);

  assign clk_o = |(clk_src_i & en_i);

endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int N  = 3,
  parameter int SW = sel_bits(N)
) (
  input  logic [N-1:0]  clk_src_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic          clk_o,
  output logic [N-1:0]  en_o
);

  logic [N-1:0] busy;
  logic [N-1:0] peer_busy;
  logic [N-1:0] en;

  for (genvar g = 0; g < N; g++) begin : g_path
    clksw_path #(
      .N   (N),
      .IDX (g),
      .SW  (SW)
    ) u_path (
      .clk_i       (clk_src_i[g]),
      .rst_ni      (rst_ni),
      .sel_i       (sel_i),
      .peer_busy_i (peer_busy[g]),
      .busy_o      (busy[g]),
      .en_o        (en[g])
    );

    localparam logic [N-1:0] SELF = N'(1) << g;

    // R2
    exclusive_en_chk: assert property (@(negedge clk_src_i[g]) disable iff (!rst_ni)
      en[g] |-> ((en & ~SELF) == '0));
  end

  clksw_peers #(.N(N)) u_peers (
    .busy_i      (busy),
    .peer_busy_o (peer_busy)
  );

  clksw_gate #(.N(N)) u_gate (
    .clk_src_i (clk_src_i),
    .en_i      (en),
    .clk_o     (clk_o)
  );

  assign en_o = en;

endmodule

// File: tb/tb_clksw_top.sv
`timescale 1ns/1ps
module tb_clksw_top;

  localparam real MIN_PH = 3.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0;
  bit         run2 = 1'b0;
  logic       clk_o;
  logic [2:0] en_o;
  wire  [2:0] src = {s2, s1, s0};

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int onehot_viol = 0, width_viol = 0, edge_viol = 0;
  realtime last_t = 0.0;
  bit have_last = 1'b0;
  logic [2:0] prev_en = 3'b000;

  always #2.5 clk = ~clk;
  always #3.5 s0 = ~s0;
  always #5.7 s1 = ~s1;
  always #8.9 s2 = run2 ? ~s2 : 1'b0;

  clksw_top #(.N(3)) dut (
    .clk_src_i (src),
    .rst_ni    (rst_n),
    .sel_i     (sel),
    .clk_o     (clk_o),
    .en_o      (en_o)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // R4 phase width monitor
  always @(clk_o) begin
    if (rst_n && have_last && (($realtime - last_t) < MIN_PH - 0.001)) begin
      width_viol++;
      $display("short phase at %0t", $realtime);
    end
    last_t = $realtime;
    have_last = rst_n;
  end

  // R2 and R8 monitors
  always @(en_o) begin
    if ($countones(en_o) > 1) onehot_viol++;
    if (rst_n) begin
      for (int i = 0; i < 3; i++)
        if (en_o[i] != prev_en[i] && src[i] !== 1'b0) edge_viol++;
    end
    prev_en = en_o;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic wait_en(input logic [2:0] exp, output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (en_o == exp) begin ok = 1'b1; break; end
    end
  endtask

  task automatic follow(input int j, input int ncyc, input string rq);
    int bad = 0;
    for (int k = 0; k < ncyc; k++) begin
      wait (src[j] == 1'b0);
      wait (src[j] == 1'b1);
      #0.2;
      if (clk_o !== 1'b1) bad++;
      wait (src[j] == 1'b0);
      #0.2;
      if (clk_o !== 1'b0) bad++;
    end
    chk(bad == 0, rq, "output follows selected source, mismatches", bad, 0);
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (clk_o !== 1'b0) highs++;
    end
  endtask

  task automatic t_reset();
    int highs;
    sel = 2'd0;
    count_high(12, highs);
    chk(en_o == 3'b000, "R5", "en_o in reset", en_o, 0);
    chk(highs == 0, "R5", "clk_o high samples in reset", highs, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_stuck();
    int highs;
    bit ok;
    sel = 2'd2;
    count_high(60, highs);
    chk(en_o == 3'b000, "R7", "en_o with stuck source selected", en_o, 0);
    chk(highs == 0, "R7", "clk_o high samples with stuck source", highs, 0);
    sel = 2'd0;
    wait_en(3'b001, ok);
    chk(ok, "R7", "working source enabled after stuck one", en_o, 1);
    follow(0, 3, "R1");
    run2 = 1'b1;
  endtask

  task automatic t_latency();
    bit ok;
    sel = 2'd3;
    wait_en(3'b000, ok);
    chk(ok, "R6", "idle before latency test", en_o, 0);
    wait (s1 == 1'b1);
    wait (s1 == 1'b0);
    #0.2;
    sel = 2'd1;
    wait (s1 == 1'b1);
    #0.2;
    chk(en_o == 3'b000, "R9", "enable still clear after rising edge", en_o, 0);
    wait (s1 == 1'b0);
    #0.2;
    chk(en_o == 3'b010, "R9", "enable set at following falling edge", en_o, 2);
    follow(1, 3, "R1");
  endtask

  task automatic t_outrange();
    bit ok;
    int highs;
    sel = 2'd3;
    wait_en(3'b000, ok);
    chk(ok, "R6", "no source for index 3", en_o, 0);
    count_high(80, highs);
    chk(highs == 0, "R6", "clk_o high samples with index 3", highs, 0);
  endtask

  task automatic t_handover();
    bit ok;
    realtime t_off, t_on;
    sel = 2'd1;
    wait_en(3'b010, ok);
    chk(ok, "R3", "source 1 enabled before handover", en_o, 2);
    #1.3;
    sel = 2'd0;
    wait (en_o[1] == 1'b0);
    t_off = $realtime;
    wait (en_o[0] == 1'b1);
    t_on = $realtime;
    chk(t_on > t_off, "R3", "new enable after old drop (ps)",
        int'((t_on - t_off) * 1000.0), 1);
    chk(en_o == 3'b001, "R3", "en_o after handover", en_o, 1);
    follow(0, 2, "R1");
  endtask

  task automatic t_random();
    bit ok;
    for (int it = 0; it < 25; it++) begin
      int nxt;
      nxt = $urandom_range(0, 2);
      #($urandom_range(10, 400) * 0.1);
      sel = 2'(nxt);
      wait_en(3'(1 << nxt), ok);
      chk(ok, "R3", "random handover reaches source", en_o, 1 << nxt);
      follow(nxt, 2, "R1");
    end
  endtask

  task automatic t_hammer();
    bit ok;
    for (int it = 0; it < 40; it++) begin
      sel = 2'($urandom_range(0, 3));
      #($urandom_range(5, 60) * 0.1);
    end
    sel = 2'd2;
    wait_en(3'b100, ok);
    chk(ok, "R3", "settles after rapid changes", en_o, 4);
    follow(2, 3, "R1");
  endtask

  initial begin
    t_reset();
    t_stuck();
    t_latency();
    t_outrange();
    t_handover();
    t_random();
    t_hammer();
    chk(onehot_viol == 0, "R2", "cycles with several enables", onehot_viol, 0);
    chk(width_viol == 0, "R4", "short output phases", width_viol, 0);
    chk(edge_viol == 0, "R8", "enable changes while source high", edge_viol, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule